// File: doc/BRIEF.md
# Bypass Register with Oscillation Counter

This block is the one-bit serial bypass stage of a core test wrapper, widened so that it can also measure how fast a path oscillates. In bypass mode it gives a one-cycle serial path from the serial input to the serial output. In count mode it counts the rising edges of a free-running oscillation signal. That signal comes from a critical path closed into a ring. The count runs only while two enable inputs are both high. A timer outside this block keeps those enables high for a fixed window.

When the window closes, the test controller puts the block in shift mode. The count then leaves through the serial output, least significant bit first, and a slow tester or an on-chip comparator checks it against the value a good device gives. A slower path oscillates more slowly, so it leaves a smaller count in the same window. A clear mode zeroes the counter before each measurement. The oscillation input has no relation to the wrapper clock. It passes through a two-flop synchronizer and an edge detector, and each detected rising edge adds one to the count.

Top module: `osc_bypass_counter`

## Requirements
- R1: With `mode_sel` = 2'b00 (bypass), `ser_out` equals the value `ser_in` had at the previous rising clock edge.
- R2: After reset, and one clock after any cycle with `mode_sel` = 2'b11 (clear), the stored count is zero and `ser_out` is 0.
- R3: Oscillation edges change the count only when `mode_sel` = 2'b01 (count) and both `win_en_a` and `win_en_b` are high. In every other case, edges leave the count unchanged.
- R4: In count mode with both enables high, each rising edge of `osc_in` adds exactly one to the count, provided each level of `osc_in` lasts at least two clock cycles. The increment shows three clock edges after the input rises.
- R5: The count is 8 bits wide and stays at 255 when further edges arrive. It never wraps.
- R6: With `mode_sel` = 2'b10 (shift), `ser_out` presents bit 0 of the register. Each clock shifts the register one place toward bit 0, and `ser_in` enters bit 7. Eight shifts therefore read out the count least significant bit first and load eight new bits.
- R7: Windows that see different numbers of edges below saturation (for example 31 and 35) read out different counts, each equal to its edge count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Wrapper clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 00 bypass, 01 count, 10 shift, 11 clear |
| win_en_a | input | 1 | First count window enable |
| win_en_b | input | 1 | Second count window enable |
| osc_in | input | 1 | Asynchronous oscillation signal from the path under test |
| ser_in | input | 1 | Serial test data input |
| ser_out | output | 1 | Serial test data output (register bit 0) |

## Verification
The saturated state is the hardest to reach from the ports. Getting there takes at least 255 detected edges, and every edge must keep each level of `osc_in` for two clocks so that the synchronizer passes it. The stimulus drives long trains of four-cycle oscillation periods (254, 255, 256 and 300 edges) and sweeps every smaller count from 0 to 40. It reads each result through the serial chain. A second hard case is the last edge of a window, which is still inside the synchronizer when the window ends. The bench waits out that latency before it leaves count mode, so the expected count is exact.

// File: rtl/osc_byp_pkg.sv
package osc_byp_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'b00,
    MODE_COUNT  = 2'b01,
    MODE_SHIFT  = 2'b10,
    MODE_CLEAR  = 2'b11
  } byp_mode_e;

endpackage

// File: rtl/osc_edge_sync.sv
module osc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_in,
  output logic rise
);

  localparam int CHAIN_W = STAGES + 1;

  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[CHAIN_W-2:0], osc_in};
    end
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/osc_window_gate.sv
module osc_window_gate
  import osc_byp_pkg::*;
(
  input  byp_mode_e mode,
  input  logic      win_en_a,
  input  logic      win_en_b,
  input  logic      rise,
  output logic      count_fire
);

  logic window_open;

  assign window_open = (mode == MODE_COUNT) && win_en_a && win_en_b;
  assign count_fire  = window_open && rise;

endmodule

// File: rtl/osc_cnt_core.sv
module osc_cnt_core
  import osc_byp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  byp_mode_e        mode,
  input  logic             count_fire,
  input  logic             ser_in,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] shift_right_in(input logic [CNT_W-1:0] v,
                                                      input logic bit_in);
    return {bit_in, v[CNT_W-1:1]};
  endfunction

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    unique case (mode)
      MODE_BYPASS: cnt_d[0] = ser_in;
      MODE_COUNT:  if (count_fire) cnt_d = sat_inc(cnt_q);
      MODE_SHIFT:  cnt_d = shift_right_in(cnt_q, ser_in);
      MODE_CLEAR:  cnt_d = '0;
      default:     cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/osc_bypass_counter.sv
module osc_bypass_counter
  import osc_byp_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       win_en_a,
  input  logic       win_en_b,
  input  logic       osc_in,
  input  logic       ser_in,
  output logic       ser_out
);

  byp_mode_e        mode;
  logic             osc_rise;
  logic             count_fire;
  logic [CNT_W-1:0] cnt_q;

  assign mode = byp_mode_e'(mode_sel);

  osc_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .osc_in (osc_in),
    .rise   (osc_rise)
  );

  osc_window_gate gate_i (
    .mode       (mode),
    .win_en_a   (win_en_a),
    .win_en_b   (win_en_b),
    .rise       (osc_rise),
    .count_fire (count_fire)
  );

  osc_cnt_core #(.CNT_W(CNT_W)) core_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .count_fire (count_fire),
    .ser_in     (ser_in),
    .cnt_q      (cnt_q)
  );

  assign ser_out = cnt_q[0];

endmodule

// File: rtl/osc_bypass_counter_chk.sv
module osc_bypass_counter_chk
  import osc_byp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_sel,
  input logic             win_en_a,
  input logic             win_en_b,
  input logic             ser_in,
  input logic             ser_out,
  input logic             rise,
  input logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic open_w;
  assign open_w = (mode_sel == MODE_COUNT) && win_en_a && win_en_b;

  p_bypass_path_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == MODE_BYPASS) |=> (ser_out == $past(ser_in)));

  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == MODE_CLEAR) |=> (cnt == '0));

  p_closed_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_sel == MODE_COUNT) && !open_w) |=> $stable(cnt));

  p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (open_w && rise && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_sel == MODE_COUNT) && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  p_shift_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == MODE_SHIFT) |=> (cnt[CNT_W-1] == $past(ser_in)));

  p_shift_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == MODE_SHIFT) |=> (ser_out == $past(cnt[1])));

  p_single_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

bind osc_bypass_counter osc_bypass_counter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_sel (mode_sel),
  .win_en_a (win_en_a),
  .win_en_b (win_en_b),
  .ser_in   (ser_in),
  .ser_out  (ser_out),
  .rise     (osc_rise),
  .cnt      (cnt_q)
);

// File: tb/osc_bypass_counter_tb_top.sv
`timescale 1ns/1ps
module osc_bypass_counter_tb_top;

  localparam int W = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       win_en_a = 1'b0;
  logic       win_en_b = 1'b0;
  logic       osc_in = 1'b0;
  logic       ser_in = 1'b0;
  logic       ser_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  osc_bypass_counter dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .win_en_a (win_en_a),
    .win_en_b (win_en_b),
    .osc_in   (osc_in),
    .ser_in   (ser_in),
    .ser_out  (ser_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expect_count(input int edges);
    return (edges > 255) ? 255 : edges;
  endfunction

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_clear();
    mode_sel = 2'b11;
    cyc(1);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      osc_in = 1'b1; cyc(2);
      osc_in = 1'b0; cyc(2);
    end
    cyc(3);
  endtask

  task automatic count_window(input int n, input logic [1:0] md,
                              input logic ga, input logic gb);
    mode_sel = md; win_en_a = ga; win_en_b = gb;
    cyc(3);
    pulses(n);
  endtask

  // Shift mode: sample bit then shift, LSB first; loads new_bits via ser_in
  task automatic shift_word(input logic [W-1:0] new_bits, output int val);
    logic [W-1:0] got;
    mode_sel = 2'b10;
    for (int i = 0; i < W; i++) begin
      got[i] = ser_out;
      ser_in = new_bits[i];
      cyc(1);
    end
    ser_in = 1'b0;
    mode_sel = 2'b01; win_en_a = 1'b0; win_en_b = 1'b0;
    val = int'(got);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    logic [15:0] pat;
    cyc(3);
    check("R2 reset ser_out", int'(ser_out), 0);
    rst_n = 1'b1;
    cyc(2);
    shift_word('0, v);
    check("R2 reset count", v, 0);

    // R1: bypass one-cycle path
    pat = 16'hB4D2;
    mode_sel = 2'b00;
    for (int i = 0; i < 16; i++) begin
      ser_in = pat[i];
      cyc(1);
      check("R1 bypass", int'(ser_out), int'(pat[i]));
    end
    ser_in = 1'b0;

    // R4: sweep of edge counts
    for (int n = 0; n <= 40; n++) begin
      do_clear();
      count_window(n, 2'b01, 1'b1, 1'b1);
      shift_word('0, v);
      check("R4 count sweep", v, expect_count(n));
    end

    // R7: nominal and slower path
    do_clear(); count_window(35, 2'b01, 1'b1, 1'b1); shift_word('0, v);
    check("R7 count 35", v, 35);
    do_clear(); count_window(31, 2'b01, 1'b1, 1'b1); shift_word('0, v);
    check("R7 count 31", v, 31);

    // R3: closed windows ignore edges
    do_clear(); count_window(5, 2'b01, 1'b0, 1'b0); shift_word('0, v);
    check("R3 both enables low", v, 0);
    do_clear(); count_window(5, 2'b01, 1'b1, 1'b0); shift_word('0, v);
    check("R3 enable b low", v, 0);
    do_clear(); count_window(5, 2'b01, 1'b0, 1'b1); shift_word('0, v);
    check("R3 enable a low", v, 0);
    do_clear(); count_window(6, 2'b01, 1'b1, 1'b1);
    ser_in = 1'b0;
    count_window(5, 2'b00, 1'b1, 1'b1);
    shift_word('0, v);
    check("R3 bypass ignores edges", v, 6);

    // R2: clear after a nonzero count
    do_clear(); count_window(9, 2'b01, 1'b1, 1'b1);
    do_clear();
    check("R2 clear ser_out", int'(ser_out), 0);
    shift_word('0, v);
    check("R2 clear count", v, 0);

    // R6: load a word through shift, read it back, counting continues from it
    shift_word(8'h3C, v);
    shift_word(8'h00, v);
    check("R6 shift load readback", v, 8'h3C);
    shift_word(8'h81, v);
    count_window(2, 2'b01, 1'b1, 1'b1);
    shift_word('0, v);
    check("R6 loaded then counted", v, 8'h83);

    // R5: saturation boundary
    for (int k = 0; k < 4; k++) begin
      int n;
      n = (k == 0) ? 254 : (k == 1) ? 255 : (k == 2) ? 256 : 300;
      do_clear();
      count_window(n, 2'b01, 1'b1, 1'b1);
      shift_word('0, v);
      check("R5 saturation", v, expect_count(n));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule